// File: doc/BRIEF.md
# Per-Operator Self-Test Signature Register

This block is the test-side bookkeeping for a chain of arithmetic operator blocks. Each operator presents the value held in its output register, an expected value and a strobe that marks the result as valid. In test mode a comparator per operator checks the result against the expectation on that strobe. The outcome goes into one bit of a signature register that the operator owns: 1 means no failure has been seen, and 0 means a mismatch was recorded.

A recorded failure is sticky. The bit holds 0 until the signature register is read. A read returns the current contents in the same cycle and re-arms every bit to 1 at the following clock edge. Test mode has two variants. Global testing lets every operator update its bit at once. Detail testing lets only the operator chosen by an index update its bit. In normal mode the register is frozen.

Top module: `st_signature_top`

## Requirements
- R1: After reset every bit of `sig_o` is 1.
- R2: `mode_i` encodes 2'b00 normal, 2'b01 global test, 2'b10 detail test and 2'b11 reserved, and reserved behaves exactly like normal.
- R3: In test mode, a strobed operator whose result differs from its expected value has its bit at 0 after the next rising edge.
- R4: A strobed operator whose result matches, or an operator without a strobe, leaves its bit unchanged.
- R5: A bit at 0 stays 0 through later matching compares until a read in test mode.
- R6: With `rd_en_i` high in a test mode, `sig_o` shows the current contents in that cycle, and every bit is 1 after the edge.
- R7: In detail mode only the operator whose index equals `op_sel_i` (bit i of `sig_o` belongs to operator i) may change its bit.
- R8: In global mode all operators update their bits in the same cycle.
- R9: Entering a test mode from normal or reserved sets every bit to 1. Switching between global and detail does not.
- R10: In normal or reserved mode, strobes and reads leave `sig_o` unchanged.
- R11: When a read and a mismatch fall in the same cycle, the mismatching bit is 0 after the edge and all other bits are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Operating mode |
| op_sel_i | input | SEL_W | Operator index for detail testing |
| strobe_i | input | N_OPS | Per-operator result-valid strobe |
| result_i | input | N_OPS*DATA_W | Operator output registers, operator i at bits [i*DATA_W +: DATA_W] |
| expect_i | input | N_OPS*DATA_W | Expected results, same packing |
| rd_en_i | input | 1 | Signature read |
| sig_o | output | N_OPS | Signature register contents |

## Verification
The read re-arm and a new failure can land on the same edge. If the clear were to win, a genuine fault would be lost without any trace. The bench provokes this by raising the read and a mismatching strobe on one operator in the same cycle. It expects that operator's bit alone to read 0 afterwards, and it checks that the next read starts from an all-ones value. Mode entry combined with the selection index is also exercised, so a preset is shown to occur only when test mode is first entered.

// File: rtl/st_sig_pkg.sv
package st_sig_pkg;
   typedef enum logic [1:0] {
      MODE_NORMAL = 2'b00,
      MODE_GLOBAL = 2'b01,
      MODE_DETAIL = 2'b10,
      MODE_RSVD   = 2'b11
   } st_mode_e;

   function automatic logic mode_is_test(input logic [1:0] m);
      return (m == MODE_GLOBAL) || (m == MODE_DETAIL);
   endfunction
endpackage

// File: rtl/st_mode_ctrl.sv
module st_mode_ctrl
   import st_sig_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode_i,
   input  logic       rd_en_i,
   output logic       test_o,
   output logic       detail_o,
   output logic       clear_o
);
   logic test_q;

   assign test_o   = mode_is_test(mode_i);
   assign detail_o = (mode_i == MODE_DETAIL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) test_q <= 1'b0;
      else        test_q <= test_o;
   end

   // preset on entry, re-arm on a read while testing
   assign clear_o = test_o & (~test_q | rd_en_i);

   p_entry_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (test_o && !$past(test_o)) |-> clear_o);
endmodule

// File: rtl/st_cmp_bank.sv
module st_cmp_bank #(
   parameter int N_OPS  = 8,
   parameter int DATA_W = 16,
   parameter int SEL_W  = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    test_i,
   input  logic                    detail_i,
   input  logic [SEL_W-1:0]        sel_i,
   input  logic [N_OPS-1:0]        strobe_i,
   input  logic [N_OPS*DATA_W-1:0] result_i,
   input  logic [N_OPS*DATA_W-1:0] expect_i,
   output logic [N_OPS-1:0]        fail_o
);
   logic [N_OPS-1:0] en;

   for (genvar i = 0; i < N_OPS; i++) begin : g_cmp
      logic mism;
      assign en[i]     = test_i & (~detail_i | (sel_i == SEL_W'(i)));
      assign mism      = result_i[i*DATA_W +: DATA_W] != expect_i[i*DATA_W +: DATA_W];
      assign fail_o[i] = en[i] & strobe_i[i] & mism;
   end

   p_detail_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      detail_i |-> $onehot0(fail_o));
   p_no_fail_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !test_i |-> (fail_o == '0));
endmodule

// File: rtl/st_sig_store.sv
module st_sig_store #(
   parameter int N_OPS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic [N_OPS-1:0] fail_i,
   output logic [N_OPS-1:0] sig_o
);
   logic [N_OPS-1:0] sig_q;

   // a failure on the clearing edge survives into the fresh register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sig_q <= '1;
      else        sig_q <= (clear_i ? '1 : sig_q) & ~fail_i;
   end

   assign sig_o = sig_q;

   p_fail_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (|fail_i) |=> ((sig_q & $past(fail_i)) == '0));
   p_quiet_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (fail_i == '0 && !clear_i) |=> $stable(sig_q));
   p_rearm_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (clear_i && fail_i == '0) |=> (sig_q == '1));
   p_collide_r11: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (sig_q == ~$past(fail_i)));
endmodule

// File: rtl/st_signature_top.sv
module st_signature_top
   import st_sig_pkg::*;
#(
   parameter int   N_OPS  = 8,
   parameter int   DATA_W = 16,
   localparam int  SEL_W  = (N_OPS > 1) ? $clog2(N_OPS) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [1:0]              mode_i,
   input  logic [SEL_W-1:0]        op_sel_i,
   input  logic [N_OPS-1:0]        strobe_i,
   input  logic [N_OPS*DATA_W-1:0] result_i,
   input  logic [N_OPS*DATA_W-1:0] expect_i,
   input  logic                    rd_en_i,
   output logic [N_OPS-1:0]        sig_o
);
   if (N_OPS < 2 || N_OPS > 32) begin : g_bad_nops
      $error("N_OPS must lie in 2..32");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be at least 1");
   end

   logic             test_w, detail_w, clear_w;
   logic [N_OPS-1:0] fail_w;

   st_mode_ctrl u_mode (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .rd_en_i(rd_en_i),
      .test_o(test_w), .detail_o(detail_w), .clear_o(clear_w)
   );

   st_cmp_bank #(.N_OPS(N_OPS), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_cmp (
      .clk(clk), .rst_n(rst_n), .test_i(test_w), .detail_i(detail_w),
      .sel_i(op_sel_i), .strobe_i(strobe_i), .result_i(result_i),
      .expect_i(expect_i), .fail_o(fail_w)
   );

   st_sig_store #(.N_OPS(N_OPS)) u_store (
      .clk(clk), .rst_n(rst_n), .clear_i(clear_w), .fail_i(fail_w), .sig_o(sig_o)
   );

   p_frozen_normal_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_is_test(mode_i) |=> $stable(sig_o));
   p_rsvd_as_normal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == MODE_RSVD) |=> $stable(sig_o));
endmodule

// File: tb/sim_st_signature_top.sv
module sim_st_signature_top;
   localparam int N  = 8;
   localparam int DW = 16;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [1:0]      mode = 2'b00;
   logic [2:0]      sel = '0;
   logic [N-1:0]    strobe = '0;
   logic [N*DW-1:0] res = '0;
   logic [N*DW-1:0] expv = '0;
   logic            rd = 1'b0;
   logic [N-1:0]    sig;
   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   st_signature_top #(.N_OPS(N), .DATA_W(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .mode_i(mode), .op_sel_i(sel), .strobe_i(strobe),
      .result_i(res), .expect_i(expv), .rd_en_i(rd), .sig_o(sig)
   );

   task automatic chk(input string req, input logic [N-1:0] exp_v);
      checks++;
      if (sig !== exp_v) begin
         fails++;
         $display("FAIL %s: sig_o=%h expected=%h", req, sig, exp_v);
      end
   endtask

   // one cycle: drive at negedge, edge, sample at next negedge
   task automatic cyc(input logic [N-1:0] stb, input logic [N-1:0] bad, input logic r);
      for (int i = 0; i < N; i++) begin
         res[i*DW +: DW]  = 16'h1000 + 16'(i);
         expv[i*DW +: DW] = bad[i] ? 16'h2222 : 16'h1000 + 16'(i);
      end
      strobe = stb;
      rd = r;
      @(posedge clk);
      @(negedge clk);
      strobe = '0;
      rd = 1'b0;
   endtask

   task automatic t_reset_and_normal();
      chk("R1 reset", 8'hFF);
      mode = 2'b00;
      cyc(8'hFF, 8'h01, 1'b0);
      chk("R10 normal ignores mismatch", 8'hFF);
   endtask

   task automatic t_global();
      mode = 2'b01;
      cyc('0, '0, 1'b0);
      chk("R9 entry preset", 8'hFF);
      cyc(8'h26, 8'h22, 1'b0);
      chk("R3 R8 global mismatches", 8'hDD);
      cyc(8'h02, 8'h00, 1'b0);
      chk("R5 sticky after match", 8'hDD);
      cyc(8'h00, 8'hFF, 1'b0);
      chk("R4 no strobe no change", 8'hDD);
   endtask

   task automatic t_frozen();
      mode = 2'b00;
      cyc(8'h01, 8'h01, 1'b1);
      chk("R10 normal read and strobe ignored", 8'hDD);
      mode = 2'b11;
      cyc(8'hFF, 8'hFF, 1'b1);
      chk("R2 reserved acts as normal", 8'hDD);
   endtask

   task automatic t_detail();
      mode = 2'b01;
      cyc(8'h08, 8'h08, 1'b0);
      chk("R9 re-entry preset then R3", 8'hF7);
      mode = 2'b10;
      sel = 3'd6;
      cyc('0, '0, 1'b0);
      chk("R9 no preset global to detail", 8'hF7);
      cyc(8'hFF, 8'hFF, 1'b0);
      chk("R7 only selected op updates", 8'hB7);
   endtask

   task automatic t_read();
      rd = 1'b1;
      #1;
      chk("R6 read shows contents", 8'hB7);
      cyc('0, '0, 1'b1);
      chk("R6 re-armed after read", 8'hFF);
   endtask

   task automatic t_collision();
      mode = 2'b01;
      cyc(8'h01, 8'h01, 1'b0);
      chk("R3 setup before collision", 8'hFE);
      cyc(8'h10, 8'h10, 1'b1);
      chk("R11 read plus mismatch", 8'hEF);
      cyc('0, '0, 1'b0);
      chk("R11 survives next cycle", 8'hEF);
      cyc('0, '0, 1'b1);
      chk("R6 next read starts clean", 8'hFF);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_and_normal();
      t_global();
      t_frozen();
      t_detail();
      t_read();
      t_collision();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #400000;
      fails++;
      checks++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule